// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets a bus master read and write a bank of 8-bit registers inside the chip. The SCL and SDA inputs are sampled with a fast system clock through short synchronizer chains. START and STOP conditions, and the rising and falling edges of SCL, are detected on the synchronized copies. The target answers a 7-bit device address made of five fixed bits followed by two strap inputs. It pulls SDA low only through an open-drain enable, `sda_oe`, and uses it both for acknowledge bits and for read data.

An 8-bit register pointer is loaded from the first byte written after the device address. Every data byte written after that goes to the pointer, and the pointer then advances by one. To do a random read, the master sets the pointer in a write phase, issues a repeated START and addresses the target for reading. Registers then stream out, starting at the pointer, for as long as the master acknowledges each byte.

The register side is a plain parallel port with no handshake and no back-pressure. `reg_addr` always shows the pointer. `reg_rdata` must be a combinational function of `reg_addr` and must be valid in the same cycle. A write is a one-cycle `reg_we` pulse, and the register file must accept it unconditionally. The system clock must run at least 8 times faster than SCL.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The device address byte (MSB first) is 1,0,1,0,1, then strap[1], then strap[0], then the read/write bit (1 = read). When it matches, the target drives ACK (SDA low on the 9th clock). When it does not match, the target leaves SDA released for every later clock and writes nothing until the next START.
- R2: In a write, the target acknowledges the address byte, the register-address byte and the data byte. Each data byte causes one `reg_we` pulse, exactly one clock long, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. A register-address byte alone causes no write.
- R3: Each extra data byte in the same write goes to the next pointer value.
- R4: After a repeated START with read/write = 1 is acknowledged, the target shifts out the register at the pointer, MSB first, one bit per SCL clock.
- R5: Each time the master acknowledges a read byte, the pointer advances by one and the next register follows on the next eight clocks.
- R6: After the master does not acknowledge a read byte, the target releases SDA and does not drive it again before a START.
- R7: The pointer wraps from 0xFF to 0x00 in both writes and reads.
- R8: A STOP at any point aborts the transfer, and a partly received data byte is not written. A START at any point restarts address reception.
- R9: `sda_oe` changes only while SCL is low, except when it is cleared by a START or a STOP. The target releases SDA for the acknowledge clock that follows each byte it sends.
- R10: While reset is held and after it is released, `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 2 | Low two bits of the device address |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at reg_addr, combinational |

## Verification
The hardest situations to reach are transfers that end in the middle of a byte and the master's NACK at the end of a read. In these cases the target has to drop its half-finished work and keep SDA released. The bench reaches them with bus tasks that clock only part of a byte before issuing STOP or a repeated START. After a NACK, it keeps clocking SCL with SDA released and confirms that the line never goes low. Random writes and reads of one to four bytes, some of them across the 0xFF boundary, are checked against a register model kept in the bench.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK,
    PH_SEND,
    PH_MACK,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    RK_DEV,
    RK_REG,
    RK_DATA
  } rkind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_dev_match.sv
module i2c_dev_match #(
  parameter int          FIXED_W    = 5,
  parameter int          STRAP_W    = 2,
  parameter logic [FIXED_W-1:0] FIXED_BITS = 5'b10101
) (
  input  logic [FIXED_W+STRAP_W:0] addr_byte,
  input  logic [STRAP_W-1:0]       strap,
  output logic                     match,
  output logic                     rw
);
  localparam int ADDR_W = FIXED_W + STRAP_W;

  assign match = (addr_byte[ADDR_W:STRAP_W+1] == FIXED_BITS) &&
                 (addr_byte[STRAP_W:1] == strap);
  assign rw    = addr_byte[0];
endmodule

// File: rtl/i2c_ptr.sv
module i2c_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end

  // R7: pointer rolls over to zero
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && ptr == '1) |=> (ptr == '0));

  // R5: an advance moves exactly one step
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (ptr == AW'($past(ptr) + 1'b1)));
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2c_rb_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          AW          = 8,
  parameter int          STRAP_W     = 2,
  parameter logic [4:0]  DEV_FIXED   = 5'b10101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic [AW-1:0]      reg_addr,
  output logic [7:0]         reg_wdata,
  output logic               reg_we,
  input  logic [7:0]         reg_rdata
);
  localparam int BYTE_W  = 8;
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int FIXED_W = BYTE_W - 1 - STRAP_W;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic dev_match, dev_rw;

  phase_t            ph;
  rkind_t            kind;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BIT_W-1:0]  bit_n;
  logic              byte_full;
  logic              rw_q;
  logic              oe_q;
  logic              we_q;
  logic [BYTE_W-1:0] wd_q;
  logic              mack_ok;
  logic              ptr_load;
  logic              ptr_inc;
  logic [AW-1:0]     ptr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_dev_match #(.FIXED_W(FIXED_W), .STRAP_W(STRAP_W),
                  .FIXED_BITS(FIXED_W'(DEV_FIXED))) u_match (
    .addr_byte(rx_sh), .strap(strap), .match(dev_match), .rw(dev_rw)
  );

  assign ptr_load = (ph == PH_RECV) && scl_fall && byte_full && (kind == RK_REG);
  assign ptr_inc  = we_q || ((ph == PH_MACK) && scl_rise && !sda_s);

  i2c_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(AW'(rx_sh)),
    .inc(ptr_inc), .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      kind      <= RK_DEV;
      rx_sh     <= '0;
      tx_sh     <= '0;
      bit_n     <= '0;
      byte_full <= 1'b0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      wd_q      <= '0;
      mack_ok   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_evt) begin
        ph   <= PH_IDLE;
        oe_q <= 1'b0;
      end else if (start_evt) begin
        ph        <= PH_RECV;
        kind      <= RK_DEV;
        bit_n     <= '0;
        byte_full <= 1'b0;
        oe_q      <= 1'b0;
      end else begin
        case (ph)
          PH_RECV: begin
            if (scl_rise && !byte_full) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_n <= bit_n + 1'b1;
              if (bit_n == LAST_BIT) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bit_n     <= '0;
              case (kind)
                RK_DEV: begin
                  if (dev_match) begin
                    rw_q <= dev_rw;
                    oe_q <= 1'b1;
                    ph   <= PH_ACK;
                  end else begin
                    ph <= PH_SKIP;
                  end
                end
                RK_REG: begin
                  oe_q <= 1'b1;
                  ph   <= PH_ACK;
                end
                default: begin
                  wd_q <= rx_sh;
                  we_q <= 1'b1;
                  oe_q <= 1'b1;
                  ph   <= PH_ACK;
                end
              endcase
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              bit_n <= '0;
              if (kind == RK_DEV && rw_q) begin
                ph    <= PH_SEND;
                tx_sh <= reg_rdata;
                oe_q  <= ~reg_rdata[BYTE_W-1];
              end else begin
                oe_q <= 1'b0;
                ph   <= PH_RECV;
                kind <= (kind == RK_DEV) ? RK_REG : RK_DATA;
              end
            end
          end
          PH_SEND: begin
            if (scl_fall) begin
              if (bit_n == LAST_BIT) begin
                oe_q <= 1'b0;
                ph   <= PH_MACK;
              end else begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                oe_q  <= ~tx_sh[BYTE_W-2];
                bit_n <= bit_n + 1'b1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              mack_ok <= !sda_s;
            end else if (scl_fall) begin
              if (mack_ok) begin
                ph    <= PH_SEND;
                bit_n <= '0;
                tx_sh <= reg_rdata;
                oe_q  <= ~reg_rdata[BYTE_W-1];
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;
  assign reg_addr  = ptr;

  // R6 / R1: quiet states never pull the line
  assert_quiet_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE || ph == PH_SKIP || ph == PH_MACK) |-> !oe_q);

  // R9: line drive changes only with SCL low, unless a bus condition cleared it
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!scl_s || $past(start_evt || stop_evt)));

  // R2: write strobe lasts one clock and only in a write transfer
  assert_we_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  assert_we_write_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> !rw_q);

  // R4: data is only sent after a read-direction address was accepted
  assert_send_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_SEND) |-> rw_q);
endmodule

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, reg_we, sda_bus;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] rf [256];
  logic [7:0] model [256];
  int checks = 0, errors = 0, wr_cnt = 0, we_double = 0, oe_bad = 0;
  logic we_prev = 1'b0, oe_prev = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus   = sda_m & ~sda_oe;
  assign reg_rdata = rf[reg_addr];

  i2c_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .strap(strap), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] dev_byte(logic [1:0] st, bit rd);
    return {5'b10101, st, rd};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= init_val(i);
    end else begin
      if (reg_we) begin
        rf[reg_addr] <= reg_wdata;
        wr_cnt++;
      end
      if (reg_we && we_prev) we_double++;
      if (sda_oe !== oe_prev && scl_m) oe_bad++;
    end
    we_prev <= reg_we;
    oe_prev <= sda_oe;
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(QTR);
    scl_m = 1'b1; tick(QTR);
    sda_m = 1'b1; tick(2 * QTR);
  endtask

  task automatic clock_bit(input bit b, output bit seen);
    sda_m = b;    tick(QTR);
    scl_m = 1'b1; tick(QTR);
    seen = sda_bus;
    tick(QTR);
    scl_m = 1'b0; tick(QTR);
  endtask

  task automatic write_byte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    clock_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v, output bit ninth);
    bit s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      v = {v[6:0], s};
    end
    clock_bit(!mack, ninth);
  endtask

  task automatic reg_write(input logic [7:0] ra, input int n, input string req);
    bit a;
    logic [7:0] d;
    int w0 = wr_cnt;
    bus_start();
    write_byte(dev_byte(strap, 1'b0), a); check_eq("R1", "dev ack", a, 1);
    write_byte(ra, a);                     check_eq("R2", "reg ack", a, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      write_byte(d, a); check_eq("R2", "data ack", a, 1);
      model[8'(ra + k)] = d;
    end
    bus_stop();
    check_eq(req, "write count", wr_cnt - w0, n);
    for (int k = 0; k < n; k++)
      check_eq(req, "stored byte", rf[8'(ra + k)], model[8'(ra + k)]);
  endtask

  task automatic reg_read(input logic [7:0] ra, input int n, input string req);
    bit a, nin;
    logic [7:0] v;
    bus_start();
    write_byte(dev_byte(strap, 1'b0), a); check_eq("R1", "dev ack", a, 1);
    write_byte(ra, a);                     check_eq("R2", "reg ack", a, 1);
    bus_start();
    write_byte(dev_byte(strap, 1'b1), a); check_eq("R4", "read dev ack", a, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, v, nin);
      check_eq(req, "read byte", v, model[8'(ra + k)]);
    end
    check_eq("R9", "released on last ack clock", nin, 1);
    bus_stop();
  endtask

  initial begin
    bit a, s, nin;
    logic [7:0] v;
    int w0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = init_val(i);
    tick(5);
    check_eq("R10", "oe in reset", sda_oe, 0);
    check_eq("R10", "we in reset", reg_we, 0);
    rst_n = 1'b1;
    tick(5);
    check_eq("R10", "oe after reset", sda_oe, 0);
    check_eq("R10", "we after reset", reg_we, 0);

    reg_write(8'h10, 1, "R2");
    reg_read(8'h10, 1, "R4");
    reg_write(8'h20, 4, "R3");
    reg_read(8'h20, 4, "R5");
    reg_write(8'hFE, 3, "R7");
    reg_read(8'hFD, 4, "R7");

    // R1: wrong strap bits, then wrong fixed bits
    w0 = wr_cnt;
    bus_start();
    write_byte(dev_byte(~strap, 1'b0), a); check_eq("R1", "strap mismatch nack", a, 0);
    write_byte(8'h30, a);                   check_eq("R1", "ignored reg byte", a, 0);
    write_byte(8'h99, a);                   check_eq("R1", "ignored data byte", a, 0);
    bus_stop();
    bus_start();
    write_byte({5'b10111, strap, 1'b0}, a); check_eq("R1", "fixed mismatch nack", a, 0);
    write_byte(8'h30, a);                   check_eq("R1", "ignored reg byte", a, 0);
    bus_stop();
    check_eq("R1", "no write on mismatch", wr_cnt - w0, 0);
    check_eq("R1", "reg untouched", rf[8'h30], model[8'h30]);

    // R6: NACK, then further clocks must see a released line
    bus_start();
    write_byte(dev_byte(strap, 1'b0), a);
    write_byte(8'h40, a);
    bus_start();
    write_byte(dev_byte(strap, 1'b1), a); check_eq("R4", "read dev ack", a, 1);
    read_byte(1'b0, v, nin);
    check_eq("R6", "nacked byte", v, model[8'h40]);
    check_eq("R6", "line free on nack", nin, 1);
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      check_eq("R6", "line free after nack", s, 1);
    end
    bus_stop();

    // R8: STOP in the middle of a data byte
    w0 = wr_cnt;
    bus_start();
    write_byte(dev_byte(strap, 1'b0), a);
    write_byte(8'h50, a);
    for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
    bus_stop();
    check_eq("R8", "aborted byte not written", wr_cnt - w0, 0);
    // R2: register byte alone then STOP writes nothing
    bus_start();
    write_byte(dev_byte(strap, 1'b0), a);
    write_byte(8'h58, a);
    bus_stop();
    check_eq("R2", "pointer-only writes nothing", wr_cnt - w0, 0);
    // R8: repeated START in the middle of a data byte
    bus_start();
    write_byte(dev_byte(strap, 1'b0), a);
    write_byte(8'h60, a);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
    bus_start();
    write_byte(dev_byte(strap, 1'b1), a); check_eq("R8", "restart dev ack", a, 1);
    read_byte(1'b0, v, nin);
    check_eq("R8", "read after restart", v, model[8'h60]);
    bus_stop();
    check_eq("R8", "no write across restart", wr_cnt - w0, 0);

    // R1: other strap value
    strap = 2'b01;
    tick(4);
    reg_write(8'h70, 1, "R1");
    reg_read(8'h70, 1, "R1");

    for (int it = 0; it < 40; it++) begin
      logic [7:0] ra;
      int n;
      ra = 8'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) reg_write(ra, n, "R3");
      else reg_read(ra, n, "R5");
    end

    check_eq("R9", "oe changed with SCL high", oe_bad, 0);
    check_eq("R2", "strobe longer than one clock", we_double, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule